// File: doc/BRIEF.md
# Interrupt Flag Collector with Read-to-Clear Status

This block gathers single-cycle event pulses from six interrupt sources and holds each one in a sticky flag. Three sources are primary: periodic tick, alarm match and end of time update. The other three are extended: memory clear, wake-up and kickstart. Software reaches the block through a small local register window. Two registers hold per-source enables. Two hold the flags. A fifth shows the battery-valid status.

Each flag is ANDed with its enable, and the six results are ORed into one summary bit. That bit drives an active-low interrupt request line. A single read of the primary status register returns all three primary flags and the summary bit, and clears the three primary flags at once. Extended flags are cleared only by writing 0 to their bit. An event that arrives in the same cycle as a clear is never lost.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every flag and every enable is 0, and `irq_n` is 1.
- R2: A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets the matching primary flag at the next clock edge, whatever the enables hold. The flags read at address 1 as bit 6 (periodic), bit 5 (alarm) and bit 4 (update).
- R3: At address 1, bits 3..0 always read 0. Writes to address 1 change nothing.
- R4: A read at address 1 (`bus_rd` high) returns the flags held before the edge, then clears all three primary flags on that edge.
- R5: A primary event that arrives in the same cycle as a read of address 1 leaves its flag set after that edge.
- R6: Address 0 holds the primary enables: bit 6 for periodic, bit 5 for alarm and bit 4 for update. They are writable and read back, and its other bits read 0.
- R7: Address 3 holds the extended flags: bit 2 for memory clear, bit 1 for wake-up and bit 0 for kickstart. They are set by `ev_ramclr`, `ev_wake` and `ev_kick`. Writing 0 to a bit clears it. Writing 1 has no effect, and reading has no effect. An event in the same cycle as a write of 0 leaves the flag set. Bits 7..3 read 0.
- R8: Address 4 holds the extended enables in bits 2..0, in the same source order as R7. Its other bits read 0.
- R9: Bit 7 at address 1 is the summary flag. It is the OR over all six sources of flag AND enable.
- R10: `irq_n` is 0 exactly while the summary flag is 1.
- R11: Address 2 reads `vrt_in` on bit 7 and 0 on bits 6..0.
- R12: Addresses 5 to 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_periodic | input | 1 | Periodic tick event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| ev_ramclr | input | 1 | Memory-clear event pulse |
| ev_wake | input | 1 | Wake-up event pulse |
| ev_kick | input | 1 | Kickstart event pulse |
| vrt_in | input | 1 | Battery-valid status shown at address 2 |
| bus_addr | input | 3 | Local register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears primary flags at address 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag that is wrongly set or stuck shows on the next edge in two places: `irq_n`, when its enable is on, and the status read, whether or not the enable is on. A clear that is too wide or too narrow shows in the second read of the same register, one cycle later. A lost coincident event shows the same way. A wrong enable bit shows in the summary bit and in `irq_n` as soon as its flag sets, because the bench sweeps every enable pattern against every event pattern.

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_periodic,
  input  logic          ev_alarm,
  input  logic          ev_update,
  input  logic          ev_ramclr,
  input  logic          ev_wake,
  input  logic          ev_kick,
  input  logic          vrt_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_EN   = AW'(0);
  localparam logic [AW-1:0] A_FLG  = AW'(1);
  localparam logic [AW-1:0] A_STS  = AW'(2);
  localparam logic [AW-1:0] A_XFLG = AW'(3);
  localparam logic [AW-1:0] A_XEN  = AW'(4);

  logic [2:0] c_flags, c_en, x_flags, x_en;
  logic       summary;
  logic       unused_wbits;

  wire rd_c  = bus_rd && (bus_addr == A_FLG);
  wire wr_x  = bus_wr && (bus_addr == A_XFLG);
  wire [2:0] c_ev = {ev_periodic, ev_alarm, ev_update};
  wire [2:0] x_ev = {ev_ramclr, ev_wake, ev_kick};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_flags <= '0;
      x_flags <= '0;
      c_en    <= '0;
      x_en    <= '0;
    end else begin
      c_flags <= (rd_c ? 3'b000 : c_flags) | c_ev;
      x_flags <= (wr_x ? (x_flags & bus_wdata[2:0]) : x_flags) | x_ev;
      if (bus_wr && bus_addr == A_EN)  c_en <= bus_wdata[6:4];
      if (bus_wr && bus_addr == A_XEN) x_en <= bus_wdata[2:0];
    end
  end

  assign summary = (|(c_flags & c_en)) | (|(x_flags & x_en));
  assign irq_n   = ~summary;

  always_comb begin
    unique case (bus_addr)
      A_EN:    bus_rdata = {1'b0, c_en, 4'b0000};
      A_FLG:   bus_rdata = {summary, c_flags, 4'b0000};
      A_STS:   bus_rdata = {vrt_in, 7'b0000000};
      A_XFLG:  bus_rdata = {5'b00000, x_flags};
      A_XEN:   bus_rdata = {5'b00000, x_en};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign unused_wbits = ^{bus_wdata[7], bus_wdata[3]};
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_alarm,
  input logic          ev_periodic,
  input logic          ev_kick,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          irq_n,
  input logic [2:0]    c_flags,
  input logic [2:0]    x_flags
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_periodic |=> c_flags[2]);

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> (bus_rdata[3:0] == 4'b0000));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(1) && !ev_periodic) |=> !c_flags[2]);

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(1) && ev_alarm) |=> c_flags[1]);

  p_wclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3) && !bus_wdata[0] && !ev_kick) |=> !x_flags[0]);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((c_flags != 3'b000) || (x_flags != 3'b000)));

  p_sts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2)) |-> (bus_rdata[6:0] == 7'b0000000));
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_alarm(ev_alarm), .ev_periodic(ev_periodic),
  .ev_kick(ev_kick), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
  .c_flags(c_flags), .x_flags(x_flags)
);

// File: tb/tb_irq_flag_unit.sv
`timescale 1ns/1ps
module tb_irq_flag_unit;
  logic clk = 0, rst_n = 0;
  logic [5:0] ev = '0;
  logic vrt_in = 0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ev_periodic(ev[5]), .ev_alarm(ev[4]), .ev_update(ev[3]),
    .ev_ramclr(ev[2]), .ev_wake(ev[1]), .ev_kick(ev[0]),
    .vrt_in(vrt_in), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata; tick; bus_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [5:0] e);
    ev = e; tick; ev = '0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic exp_sum;
    repeat (3) tick;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      if (a == 2) continue;
      peek(3'(a), d); chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 reset irq_n", {7'b0, irq_n}, 8'h01);
    rst_n = 1; tick;
    chk("R1 irq_n after release", {7'b0, irq_n}, 8'h01);

    // R11 status register
    vrt_in = 1; peek(3'd2, d); chk("R11 vrt high", d, 8'h80);
    vrt_in = 0; peek(3'd2, d); chk("R11 vrt low", d, 8'h00);

    // Exhaustive sweep: every enable pattern against every event pattern
    for (int en = 0; en < 64; en++) begin
      wr(3'd0, {1'b1, 3'(en >> 3), 4'hF});
      wr(3'd4, {5'b11111, 3'(en)});
      peek(3'd0, d); chk("R6 enable readback", d, {1'b0, 3'(en >> 3), 4'h0});
      peek(3'd4, d); chk("R8 enable readback", d, {5'b0, 3'(en)});
      for (int e = 0; e < 64; e++) begin
        pulse(6'(e));
        exp_sum = |(6'(e) & 6'(en));
        chk("R10 irq after events", {7'b0, irq_n}, {7'b0, ~exp_sum});
        rd(3'd3, d); chk("R7 ext flags", d, {5'b0, 3'(e)});
        rd(3'd1, d); chk("R2 R9 R3 primary read", d, {exp_sum, 3'(e >> 3), 4'h0});
        exp_sum = |(3'(e) & 3'(en));
        peek(3'd1, d); chk("R4 cleared after read", d, {exp_sum, 3'b000, 4'h0});
        chk("R10 irq after primary clear", {7'b0, irq_n}, {7'b0, ~exp_sum});
        peek(3'd3, d); chk("R7 read does not clear", d, {5'b0, 3'(e)});
        wr(3'd3, 8'h00);
        peek(3'd3, d); chk("R7 write zero clears", d, 8'h00);
        chk("R10 irq idle", {7'b0, irq_n}, 8'h01);
      end
    end

    // R5: event coincident with the clearing read
    wr(3'd0, 8'h70); wr(3'd4, 8'h07);
    pulse(6'b111000);
    bus_addr = 3'd1; bus_rd = 1; ev = 6'b010000; tick; bus_rd = 0; ev = '0;
    peek(3'd1, d); chk("R5 coincident event kept", d, 8'hA0);
    rd(3'd1, d); peek(3'd1, d); chk("R5 later read clears", d, 8'h00);

    // R7: write 1 keeps, write 0 clears selectively, coincident event wins
    pulse(6'b000111);
    wr(3'd3, 8'hFF); peek(3'd3, d); chk("R7 write one no effect", d, 8'h07);
    wr(3'd3, 8'h05); peek(3'd3, d); chk("R7 clear wake only", d, 8'h05);
    bus_addr = 3'd3; bus_wdata = 8'h00; bus_wr = 1; ev = 6'b000001; tick;
    bus_wr = 0; ev = '0;
    peek(3'd3, d); chk("R7 coincident kick kept", d, 8'h01);
    wr(3'd3, 8'h00);

    // R3: writes to the primary status register are ignored
    pulse(6'b100000);
    wr(3'd1, 8'h00); peek(3'd1, d); chk("R3 write ignored", d, 8'hC0);
    wr(3'd1, 8'hFF); peek(3'd1, d); chk("R3 low bits zero", d, 8'hC0);
    rd(3'd1, d);

    // R12: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      peek(3'(a), d); chk("R12 unmapped reads zero", d, 8'h00);
    end
    peek(3'd0, d); chk("R12 enables untouched", d, 8'h70);
    peek(3'd4, d); chk("R12 ext enables untouched", d, 8'h07);
    peek(3'd3, d); chk("R12 ext flags untouched", d, 8'h00);
    chk("R12 irq untouched", {7'b0, irq_n}, 8'h01);

    // R9: flag without enable keeps summary low
    wr(3'd0, 8'h00); wr(3'd4, 8'h00);
    pulse(6'b111111);
    peek(3'd1, d); chk("R9 disabled summary low", d, 8'h70);
    chk("R10 disabled irq high", {7'b0, irq_n}, 8'h01);
    wr(3'd4, 8'h02);
    chk("R9 late enable raises irq", {7'b0, irq_n}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule